// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Bridge

This block lets a CPU reach a parallel ATA/IDE device through plain register accesses, with no separate disk controller in between. Each CPU access arrives on a request channel with a window select, a byte address, a direction and write data. The byte address is scaled down by a fixed stride to give a register index. The block then runs one programmed-I/O cycle on the device side: it drives the chip selects and the register address, pulses the read or write strobe, and returns the read data on the same channel.

The task window reaches the 16-bit data register and the seven 8-bit command-block registers. The control window reaches the alternate-status register on reads and the device-control register on writes. Only the data register uses the upper byte lane. Multi-byte data is little-endian: the lower byte travels on lane 0. Both drives on the cable, unit 0 and unit 1, share these signals. The drive-select bit inside the task file picks between them, and the bridge routes it like any other byte.

The request channel follows valid/ready rules. The requester raises `req_valid` and holds window, address, direction and write data stable until it sees `req_ready`. `req_ready` is high for one cycle, once the device strobe has run its full width. The access completes in that cycle, and for reads `req_rdata` is valid in that same cycle. The bridge handles one access at a time. Every new access starts from idle. The device interrupt reaches the CPU through a register stage, and the block's reset also holds the device reset line active.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The register index is the byte address shifted right by STRIDE. In the task window (`req_win`=0), `ide_cs0_n` goes low, `ide_cs1_n` stays high, and `ide_da` carries index bits [2:0]. Index bits above bit 2 are ignored, so index 8 reaches the data register again.
- R2: In the control window (`req_win`=1), `ide_cs1_n` goes low, `ide_cs0_n` stays high, and `ide_da` is 3'b110 for any address offset. A read there returns the alternate status, and a write goes to device control.
- R3: A task-window access whose index bits [2:0] are 000 is 16-bit. A write drives `ide_dd_oe`=2'b11 with `ide_dd_out` equal to the write data. A read returns `ide_dd_in[15:0]` unchanged, with bits [7:0] as the low byte.
- R4: Every other access is 8-bit. A write drives `ide_dd_oe`=2'b01 with `ide_dd_out[15:8]`=0. A read returns `{8'h00, ide_dd_in[7:0]}`.
- R5: An accepted access first spends one setup cycle with chip select and address valid and both strobes high. The strobe for its direction (`ide_dior_n` for a read, `ide_diow_n` for a write) then stays low for exactly `strobe_len` cycles, and both strobes are never low together.
- R6: `req_ready` rises in the cycle after the strobe ends, stays high for exactly one cycle per access, and never rises unless a strobe has just finished.
- R7: With no access in progress, both chip selects and both strobes are high, and `ide_dd_oe` is 2'b00.
- R8: `irq` equals `ide_intrq` delayed by one clock.
- R9: While `rst_n` is low, `ide_rst_n` is low, `irq` is 0, `req_ready` is 0 and the device side is idle. `ide_rst_n` rises at the first clock edge after reset is released.
- R10: A `strobe_len` of 0 gives a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_len | input | CNT_W | Strobe width in cycles, 0 treated as 1 |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access complete; read data valid |
| req_win | input | 1 | 0 = task window, 1 = control window |
| req_addr | input | ADDR_W | CPU byte address within the window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, little-endian |
| req_rdata | output | 16 | Read data, zero-extended for 8-bit registers |
| irq | output | 1 | Interrupt to the CPU |
| ide_rst_n | output | 1 | Device reset, active low |
| ide_cs0_n | output | 1 | Command-block chip select |
| ide_cs1_n | output | 1 | Control-block chip select |
| ide_da | output | 3 | Device register address |
| ide_dior_n | output | 1 | Read strobe |
| ide_diow_n | output | 1 | Write strobe |
| ide_dd_out | output | 16 | Data driven toward the device |
| ide_dd_oe | output | 2 | Per-byte-lane output enable for `ide_dd_out` |
| ide_dd_in | input | 16 | Data from the device |
| ide_intrq | input | 1 | Device interrupt request |

## Verification
The strobe-width check compares against the live `strobe_len` input. It therefore assumes that input does not change while an access is in flight, even though the bridge latches it when it accepts the request. The interrupt delay check assumes `ide_intrq` is low during reset. The bench drives all inputs on the falling edge. It changes `strobe_len`, the request fields and `ide_dd_in` only between accesses, holds them through each access until `req_ready`, and keeps the interrupt line low until reset is over. Random addresses stay inside each window's span, and strobe widths stay within 0 to 5.

// File: rtl/ide_br_pkg.sv
`timescale 1ns/1ps
package ide_br_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } br_state_e;

  typedef struct packed {
    logic       ctl;   // control window
    logic       wide;  // 16-bit data register
    logic [2:0] da;    // device register address
  } br_dec_t;

  localparam logic [2:0] CTL_DA = 3'b110;

endpackage

// File: rtl/ide_br_decode.sv
`timescale 1ns/1ps
module ide_br_decode
  import ide_br_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 0
) (
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  output br_dec_t           dec
);
  localparam int IDX_W = ADDR_W - STRIDE;

  logic [IDX_W-1:0] idx;
  logic             unused_bits;

  generate
    if (STRIDE == 0) begin : g_nostride
      assign idx         = addr;
      assign unused_bits = ^idx[IDX_W-1:3];
    end else begin : g_stride
      assign idx         = addr[ADDR_W-1:STRIDE];
      assign unused_bits = ^{idx[IDX_W-1:3], addr[STRIDE-1:0]};
    end
  endgenerate

  always_comb begin
    dec.ctl  = win;
    dec.da   = win ? CTL_DA : idx[2:0];
    dec.wide = !win && (idx[2:0] == 3'b000);
  end

endmodule

// File: rtl/ide_br_timer.sv
`timescale 1ns/1ps
module ide_br_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      limit_q <= (len == '0) ? '0 : len - 1'b1;
      cnt_q   <= '0;
    end else if (run && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == limit_q);

endmodule

// File: rtl/ide_br_seq.sv
`timescale 1ns/1ps
module ide_br_seq
  import ide_br_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  input  br_dec_t       dec_in,
  input  logic          tmr_done,
  input  logic [DW-1:0] dd_in,
  output logic          tmr_load,
  output logic          tmr_run,
  output logic          req_ready,
  output logic [DW-1:0] req_rdata,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic [2:0]    da,
  output logic          dior_n,
  output logic          diow_n,
  output logic [DW-1:0] dd_out,
  output logic [1:0]    dd_oe
);
  localparam int LANE_W = DW / 2;

  br_state_e     st_q;
  br_dec_t       cur_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_next;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          cur_q   <= dec_in;
          we_q    <= req_we;
          wdata_q <= req_wdata;
          st_q    <= ST_SETUP;
        end
        ST_SETUP:  st_q <= ST_STROBE;
        ST_STROBE: if (tmr_done) begin
          if (!we_q) rdata_q <= rd_next;
          st_q <= ST_HOLD;
        end
        ST_HOLD:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign active   = (st_q != ST_IDLE);
  assign tmr_load = (st_q == ST_IDLE) && req_valid;
  assign tmr_run  = (st_q == ST_STROBE);

  // byte lanes: lane 0 always used, lane 1 only for the data register
  generate
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      logic lane_on;
      if (ln == 0) begin : g_lo
        assign lane_on = 1'b1;
      end else begin : g_hi
        assign lane_on = cur_q.wide;
      end
      assign rd_next[ln*LANE_W +: LANE_W] =
        lane_on ? dd_in[ln*LANE_W +: LANE_W] : '0;
      assign dd_out[ln*LANE_W +: LANE_W] =
        lane_on ? wdata_q[ln*LANE_W +: LANE_W] : '0;
      assign dd_oe[ln] = active && we_q && lane_on;
    end
  endgenerate

  assign cs0_n     = !(active && !cur_q.ctl);
  assign cs1_n     = !(active && cur_q.ctl);
  assign da        = active ? cur_q.da : 3'b000;
  assign dior_n    = !((st_q == ST_STROBE) && !we_q);
  assign diow_n    = !((st_q == ST_STROBE) && we_q);
  assign req_ready = (st_q == ST_HOLD);
  assign req_rdata = rdata_q;

endmodule

// File: rtl/ide_mmio_bridge.sv
`timescale 1ns/1ps
module ide_mmio_bridge
  import ide_br_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 0,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  strobe_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_win,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [15:0]       req_wdata,
  output logic [15:0]       req_rdata,
  output logic              irq,
  output logic              ide_rst_n,
  output logic              ide_cs0_n,
  output logic              ide_cs1_n,
  output logic [2:0]        ide_da,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic [15:0]       ide_dd_out,
  output logic [1:0]        ide_dd_oe,
  input  logic [15:0]       ide_dd_in,
  input  logic              ide_intrq
);
  br_dec_t dec;
  logic    tmr_load;
  logic    tmr_run;
  logic    tmr_done;

  ide_br_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
    .win  (req_win),
    .addr (req_addr),
    .dec  (dec)
  );

  ide_br_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (strobe_len),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  ide_br_seq #(.DW(16)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .dec_in    (dec),
    .tmr_done  (tmr_done),
    .dd_in     (ide_dd_in),
    .tmr_load  (tmr_load),
    .tmr_run   (tmr_run),
    .req_ready (req_ready),
    .req_rdata (req_rdata),
    .cs0_n     (ide_cs0_n),
    .cs1_n     (ide_cs1_n),
    .da        (ide_da),
    .dior_n    (ide_dior_n),
    .diow_n    (ide_diow_n),
    .dd_out    (ide_dd_out),
    .dd_oe     (ide_dd_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      ide_rst_n <= 1'b0;
    end else begin
      irq       <= ide_intrq;
      ide_rst_n <= 1'b1;
    end
  end

endmodule

// File: rtl/ide_mmio_bridge_chk.sv
`timescale 1ns/1ps
module ide_mmio_bridge_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] strobe_len,
  input logic             req_ready,
  input logic             ide_cs0_n,
  input logic             ide_cs1_n,
  input logic [2:0]       ide_da,
  input logic             ide_dior_n,
  input logic             ide_diow_n,
  input logic [1:0]       ide_dd_oe,
  input logic             ide_intrq,
  input logic             irq,
  input logic             ide_rst_n
);
  logic [CNT_W:0] low_cnt;
  logic [CNT_W:0] want_len;
  logic           run_seen;
  logic           strobe_low;

  assign strobe_low = !ide_dior_n || !ide_diow_n;
  assign want_len   = (strobe_len == '0) ? 1 : {1'b0, strobe_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      run_seen <= 1'b0;
    end else begin
      run_seen <= 1'b1;
      if (!strobe_low)          low_cnt <= '0;
      else if (!(&low_cnt))     low_cnt <= low_cnt + 1'b1;
    end
  end

  assert_cs_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_cs0_n && !ide_cs1_n));

  assert_ctl_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_cs1_n |-> ide_da == 3'b110);

  assert_hi_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ide_dd_oe[1] |-> (ide_dd_oe[0] && !ide_cs0_n && ide_da == 3'b000));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n));

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ide_dior_n) || $rose(ide_diow_n)) |-> low_cnt == want_len);

  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_ready_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $past(strobe_low));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_cs0_n && ide_cs1_n) |-> (ide_dior_n && ide_diow_n && ide_dd_oe == 2'b00));

  assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_seen |-> irq == $past(ide_intrq));

  assert_bus_reset_R9: assert property (@(posedge clk)
    !rst_n |-> (!ide_rst_n && !irq && !req_ready));

endmodule

bind ide_mmio_bridge ide_mmio_bridge_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_len (strobe_len),
  .req_ready  (req_ready),
  .ide_cs0_n  (ide_cs0_n),
  .ide_cs1_n  (ide_cs1_n),
  .ide_da     (ide_da),
  .ide_dior_n (ide_dior_n),
  .ide_diow_n (ide_diow_n),
  .ide_dd_oe  (ide_dd_oe),
  .ide_intrq  (ide_intrq),
  .irq        (irq),
  .ide_rst_n  (ide_rst_n)
);

// File: tb/ide_mmio_bridge_tb.sv
`timescale 1ns/1ps
module ide_mmio_bridge_tb;
  localparam int TB_STRIDE = 2;
  localparam int TB_ADDR_W = 8;
  localparam int TB_CNT_W  = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [TB_CNT_W-1:0]  strobe_len = '0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic                 req_win = 1'b0;
  logic [TB_ADDR_W-1:0] req_addr = '0;
  logic                 req_we = 1'b0;
  logic [15:0]          req_wdata = '0;
  logic [15:0]          req_rdata;
  logic                 irq;
  logic                 ide_rst_n;
  logic                 ide_cs0_n, ide_cs1_n;
  logic [2:0]           ide_da;
  logic                 ide_dior_n, ide_diow_n;
  logic [15:0]          ide_dd_out;
  logic [1:0]           ide_dd_oe;
  logic [15:0]          ide_dd_in = '0;
  logic                 ide_intrq = 1'b0;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  ide_mmio_bridge #(.ADDR_W(TB_ADDR_W), .STRIDE(TB_STRIDE), .CNT_W(TB_CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_len(strobe_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_win(req_win),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .irq(irq), .ide_rst_n(ide_rst_n),
    .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_da(ide_da),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
    .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe),
    .ide_dd_in(ide_dd_in), .ide_intrq(ide_intrq)
  );

  function automatic logic [2:0] f_da(input bit win, input logic [7:0] a);
    logic [7:0] idx;
    idx = a >> TB_STRIDE;
    return win ? 3'b110 : idx[2:0];
  endfunction

  function automatic bit f_wide(input bit win, input logic [7:0] a);
    return !win && (f_da(win, a) == 3'b000);
  endfunction

  function automatic int f_len(input logic [3:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // One access; called and returns on a falling edge.
  task automatic access(input bit win, input logic [7:0] addr, input bit we,
                        input logic [15:0] wd, input logic [15:0] ddin,
                        input logic [3:0] len);
    int  cyc = 0;
    int  lows = 0;
    bit  first = 1'b1;
    bit  bad_sel = 1'b0;
    bit  bad_other = 1'b0;
    bit  bad_lane = 1'b0;
    bit  setup_ok = 1'b0;
    logic [2:0]  eda  = f_da(win, addr);
    bit          wide = f_wide(win, addr);
    logic [15:0] exp_out = wide ? wd : {8'h00, wd[7:0]};
    logic [1:0]  exp_oe  = wide ? 2'b11 : 2'b01;
    logic [15:0] exp_rd  = wide ? ddin : {8'h00, ddin[7:0]};
    req_win = win; req_addr = addr; req_we = we; req_wdata = wd;
    ide_dd_in = ddin; strobe_len = len; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready || cyc > 40) break;
      cyc++;
      if (ide_cs0_n != win || ide_cs1_n != !win || ide_da != eda) bad_sel = 1'b1;
      if (first) setup_ok = ide_dior_n && ide_diow_n;
      first = 1'b0;
      if ((we ? ide_dior_n : ide_diow_n) == 1'b0) bad_other = 1'b1;
      if ((we ? ide_diow_n : ide_dior_n) == 1'b0) begin
        lows++;
        if (we && (ide_dd_oe != exp_oe || ide_dd_out != exp_out)) bad_lane = 1'b1;
        if (!we && ide_dd_oe != 2'b00) bad_lane = 1'b1;
      end
    end
    chk(!bad_sel, win ? "R2 select" : "R1 select", {ide_cs1_n, ide_cs0_n, ide_da},
        {!win, win, eda});
    chk(setup_ok, "R5 setup", setup_ok, 1);
    chk(!bad_other && lows == f_len(len), "R5/R10 strobe width", lows, f_len(len));
    chk(req_ready && cyc == 1 + f_len(len), "R6 ready timing", cyc, 1 + f_len(len));
    if (we) chk(!bad_lane, wide ? "R3 write lanes" : "R4 write lanes",
                {ide_dd_oe, ide_dd_out}, {exp_oe, exp_out});
    else    chk(req_rdata == exp_rd, wide ? "R3 read data" : "R4 read data",
                req_rdata, exp_rd);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R6 single ready", req_ready, 0);
    chk(ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && ide_dd_oe == 2'b00,
        "R7 idle", {ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dd_oe}, 6'h3c);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!ide_rst_n && !irq && !req_ready, "R9 reset outputs",
        {ide_rst_n, irq, req_ready}, 0);
    chk(ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && ide_dd_oe == 0,
        "R9 reset idle", {ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n}, 4'hf);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ide_rst_n, "R9 device reset release", ide_rst_n, 1);
    // R7: idle with no request
    repeat (3) @(negedge clk);
    chk(ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && !req_ready,
        "R7 no request", {ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n}, 4'hf);
    // R8: interrupt path
    ide_intrq = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq rise", irq, 1);
    ide_intrq = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq fall", irq, 0);

    // directed corners
    access(1'b0, 8'd0,  1'b0, 16'h0000, 16'hBEEF, 4'd0);  // R3 R10 data read, 1-cycle strobe
    access(1'b0, 8'd3,  1'b1, 16'hA55A, 16'h0000, 4'd2);  // R1 offset bits below stride ignored
    access(1'b0, 8'd28, 1'b0, 16'h0000, 16'h1287, 4'd3);  // R4 idx 7 zero-extended
    access(1'b0, 8'd32, 1'b0, 16'h0000, 16'hC0DE, 4'd1);  // R1 idx 8 aliases data register
    access(1'b0, 8'd24, 1'b1, 16'hFF3C, 16'h0000, 4'd4);  // R4 idx 6 upper lane quiet
    access(1'b1, 8'd7,  1'b0, 16'h0000, 16'h9950, 4'd2);  // R2 alt status at any offset
    access(1'b1, 8'd0,  1'b1, 16'h7706, 16'h0000, 4'd0);  // R2 device control write

    // constrained random
    for (int k = 0; k < 80; k++) begin
      bit          w   = 1'($urandom % 2);
      logic [7:0]  a   = w ? 8'($urandom % (2 << TB_STRIDE))
                           : 8'($urandom % (16 << TB_STRIDE));
      bit          we  = 1'($urandom % 2);
      logic [15:0] wd  = 16'($urandom);
      logic [15:0] dd  = 16'($urandom);
      logic [3:0]  len = 4'($urandom % 6);
      access(w, a, we, wd, dd, len);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule